// File: doc/BRIEF.md
# Multi-purpose register readout

This block models the read path of the multi-purpose register in a DDR3-style memory device. A mode-register write selects one of two states. In the normal state, reads and writes go to the memory array. This block only reports that such a command went to the array. In register mode, read commands never reach the array. Each read returns a fixed 8-bit pattern, one bit per beat, on every byte lane of a x8 or x16 data bus.

The mode-register write carries three bits. The top bit switches register mode on or off, and the two low bits choose one of four register locations. A read in register mode produces a burst of 8 or 4 beats after a fixed read latency. Burst length comes from a static burst-mode setting, or from command address bit 12 when that setting allows on-the-fly selection. Address bit 2 picks the half of the pattern for a chopped burst. Bank bits and the other column bits are ignored. Address combinations that are not allowed raise a one-cycle error flag, and the burst then runs as if the offending bits were zero.

Top module: `mpreg_readout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `reg_mode` is 0, `dq_valid` is 0, `dq` is all zero, and the four command flags are 0.
- R2: A cycle with `mrs_valid` high loads `mrs_addr`. Bit 2 enables register mode from the next cycle, and bits 1:0 select the location. A later write with bit 2 at 0 returns the block to normal operation, and bits 1:0 are then ignored.
- R3: A read in normal operation pulses `array_rd` for one cycle right after the command edge. It produces no burst and no error flag.
- R4: Location 0 returns the parameter `PATTERN` (default 8'b0101_0101). Locations 1, 2 and 3 return all zeros. Beat index k carries bit k of the pattern, so beat 0 is the LSB.
- R5: If a register-mode read is sampled at clock edge n, its first beat is on `dq` in the cycle that follows edge n+`RD_LAT`. One beat follows per cycle, and `dq_valid` is high only during the 4 or 8 beats. While `dq_valid` is low, `dq` is zero.
- R6: An 8-beat burst emits beat indices 0 to 7 in rising order. A chopped burst emits indices 0 to 3 when address bit 2 is 0, and indices 4 to 7 when it is 1.
- R7: `burst_mode` encoding: 2'b00 gives a fixed 8-beat burst, 2'b10 a fixed chopped burst, and 2'b11 is treated as 2'b00. With 2'b01 the burst length is chosen per command: address bit 12 = 1 gives 8 beats and 0 gives a chop.
- R8: `rd_bank`, address bits 3 to 11 and 13 and up never change the burst. Address bit 12 has no effect unless `burst_mode` is 2'b01.
- R9: A register-mode read with address bits 1:0 not equal to 00, or an 8-beat read with address bit 2 set, pulses `rd_addr_err` right after the command edge. Its burst is the one the same command would give with those bits at zero.
- R10: Bit 0 of every byte lane carries the beat value. When `lane_copy` is 1 the other seven bits of each byte copy it; when `lane_copy` is 0 they are 0.
- R11: A write in register mode pulses `wr_drop` right after the command edge and does not pulse `array_wr`. A write in normal operation pulses `array_wr` only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_valid | input | 1 | Mode-register write strobe |
| mrs_addr | input | 3 | Bit 2 enables register mode, bits 1:0 select the location |
| rd_valid | input | 1 | Read command strobe |
| rd_addr | input | ADDR_W (16) | Read command address bits |
| rd_bank | input | BANK_W (3) | Read command bank bits, ignored |
| wr_valid | input | 1 | Write command strobe |
| burst_mode | input | 2 | Static burst-length setting (R7) |
| lane_copy | input | 1 | 1: copy the beat to all bits of a lane; 0: only bit 0 |
| reg_mode | output | 1 | Register mode active |
| dq | output | 8*DQ_BYTES | Beat data on all byte lanes |
| dq_valid | output | 1 | High during burst beats |
| rd_addr_err | output | 1 | Illegal read address pulse |
| array_rd | output | 1 | Read sent to the array |
| array_wr | output | 1 | Write sent to the array |
| wr_drop | output | 1 | Write dropped in register mode |

## Verification
The embedded assertions check, on every cycle, the rules that hold at any moment. These are: mode tracking after each mode-register write, the routing of writes and normal reads to their one-cycle flags, the error flag only in register mode, the lane layout of `dq`, and a burst counter that never exceeds eight beats. Other behaviour shows up only in the bench's scenarios. That covers the exact beat order for each burst setting and address bit 2, the latency to the first beat, the pattern per location, and the fact that ignored address and bank bits leave the burst unchanged. The bench compares these against its cycle-by-cycle model on every clock.

// File: rtl/mpreg_pkg.sv
package mpreg_pkg;

  typedef enum logic [1:0] {
    BM_FIX8 = 2'b00,
    BM_OTF  = 2'b01,
    BM_FIX4 = 2'b10,
    BM_RSVD = 2'b11
  } burst_mode_e;

  // Burst descriptor handed from the decoder to the beat generator
  typedef struct packed {
    logic       chop;   // 4-beat burst
    logic       upper;  // start at beat index 4
    logic [7:0] pat;    // selected register content
  } burst_desc_t;

  localparam int unsigned BEATS_FULL = 8;
  localparam int unsigned BEATS_CHOP = 4;

endpackage

// File: rtl/mpreg_mode_reg.sv
module mpreg_mode_reg (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       mrs_valid_i,
  input  logic [2:0] mrs_addr_i,
  output logic       en_o,
  output logic [1:0] loc_o
);

  logic       en_q, en_d;
  logic [1:0] loc_q, loc_d;

  always_comb begin
    en_d  = en_q;
    loc_d = loc_q;
    if (mrs_valid_i) begin
      en_d  = mrs_addr_i[2];
      loc_d = mrs_addr_i[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      loc_q <= 2'b00;
    end else if (mrs_valid_i) begin
      en_q  <= en_d;
      loc_q <= loc_d;
    end
  end

  assign en_o  = en_q;
  assign loc_o = loc_q;

  // R2: mode follows the last mode-register write
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_ni)
    mrs_valid_i |=> (en_o == $past(mrs_addr_i[2])));

endmodule

// File: rtl/mpreg_cmd_decode.sv
module mpreg_cmd_decode
  import mpreg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BANK_W  = 3,
  parameter logic [7:0]  PATTERN = 8'b0101_0101
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic              wr_valid_i,
  input  logic [1:0]        burst_mode_i,
  input  logic              en_i,
  input  logic [1:0]        loc_i,
  output logic              start_o,
  output burst_desc_t       desc_o,
  output logic              addr_err_o,
  output logic              array_rd_o,
  output logic              array_wr_o,
  output logic              wr_drop_o
);

  localparam int unsigned CHOP_BIT = 12;

  burst_mode_e mode;
  logic        chop_c, err_c;
  logic [7:0]  pat_c;
  burst_desc_t desc_d, desc_q;
  logic        start_d, start_q;
  logic        err_d, err_q;
  logic        ard_d, ard_q;
  logic        awr_d, awr_q;
  logic        drop_d, drop_q;
  logic        unused_addr_bits;

  assign mode = burst_mode_e'(burst_mode_i);

  always_comb begin
    unique case (mode)
      BM_FIX4: chop_c = 1'b1;
      BM_OTF:  chop_c = ~rd_addr_i[CHOP_BIT];
      default: chop_c = 1'b0;
    endcase
  end

  assign err_c = (|rd_addr_i[1:0]) | (~chop_c & rd_addr_i[2]);
  assign pat_c = (loc_i == 2'b00) ? PATTERN : 8'h00;

  always_comb begin
    start_d      = rd_valid_i & en_i;
    err_d        = rd_valid_i & en_i & err_c;
    ard_d        = rd_valid_i & ~en_i;
    awr_d        = wr_valid_i & ~en_i;
    drop_d       = wr_valid_i & en_i;
    desc_d       = desc_q;
    if (start_d) begin
      desc_d.chop  = chop_c;
      desc_d.upper = chop_c & rd_addr_i[2];
      desc_d.pat   = pat_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      ard_q   <= 1'b0;
      awr_q   <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      err_q   <= err_d;
      ard_q   <= ard_d;
      awr_q   <= awr_d;
      drop_q  <= drop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      desc_q <= '0;
    end else if (start_d) begin
      desc_q <= desc_d;
    end
  end

  // Bank and column bits outside A[2:0] and A12 carry no meaning here
  assign unused_addr_bits = ^{rd_bank_i, rd_addr_i[ADDR_W-1:CHOP_BIT+1],
                              rd_addr_i[CHOP_BIT-1:3]};

  assign start_o    = start_q;
  assign desc_o     = desc_q;
  assign addr_err_o = err_q;
  assign array_rd_o = ard_q;
  assign array_wr_o = awr_q;
  assign wr_drop_o  = drop_q;

  // R11: writes in register mode are dropped, never forwarded
  a_r11_write_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_valid_i && en_i) |=> (wr_drop_o && !array_wr_o));

  // R3: normal-mode reads go to the array and start no burst
  a_r3_normal_read: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid_i && !en_i) |=> (array_rd_o && !start_o && !addr_err_o));

  // R9: error flag only accompanies a burst start
  a_r9_err_with_start: assert property (@(posedge clk) disable iff (!rst_ni)
    addr_err_o |-> start_o);

endmodule

// File: rtl/mpreg_beat_gen.sv
module mpreg_beat_gen
  import mpreg_pkg::*;
#(
  parameter int unsigned RD_LAT = 5
) (
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        start_i,
  input  burst_desc_t desc_i,
  output logic        beat_vld_o,
  output logic        beat_bit_o
);

  localparam int unsigned STAGES = RD_LAT - 1;

  logic        tail_vld;
  burst_desc_t tail_desc;

  generate
    if (STAGES == 0) begin : g_no_delay
      assign tail_vld  = start_i;
      assign tail_desc = desc_i;
    end else begin : g_delay
      logic        vld_q  [STAGES];
      logic        vld_d  [STAGES];
      burst_desc_t desc_q [STAGES];
      burst_desc_t desc_d [STAGES];

      always_comb begin
        for (int s = 0; s < int'(STAGES); s++) begin
          vld_d[s]  = (s == 0) ? start_i : vld_q[s-1];
          desc_d[s] = (s == 0) ? desc_i  : desc_q[s-1];
        end
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int s = 0; s < int'(STAGES); s++) begin
            vld_q[s]  <= 1'b0;
            desc_q[s] <= '0;
          end
        end else begin
          for (int s = 0; s < int'(STAGES); s++) begin
            vld_q[s]  <= vld_d[s];
            desc_q[s] <= desc_d[s];
          end
        end
      end

      assign tail_vld  = vld_q[STAGES-1];
      assign tail_desc = desc_q[STAGES-1];
    end
  endgenerate

  logic [7:0] pat_q, pat_d;
  logic [2:0] idx_q, idx_d;
  logic [3:0] left_q, left_d;
  logic       busy;

  assign busy = (left_q != 4'd0);

  always_comb begin
    pat_d  = pat_q;
    idx_d  = idx_q;
    left_d = left_q;
    if (tail_vld) begin
      pat_d  = tail_desc.pat;
      idx_d  = tail_desc.upper ? 3'd4 : 3'd0;
      left_d = tail_desc.chop ? 4'(BEATS_CHOP) : 4'(BEATS_FULL);
    end else if (busy) begin
      idx_d  = idx_q + 3'd1;
      left_d = left_q - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= 8'h00;
      idx_q  <= 3'd0;
      left_q <= 4'd0;
    end else if (tail_vld || busy) begin
      pat_q  <= pat_d;
      idx_q  <= idx_d;
      left_q <= left_d;
    end
  end

  assign beat_vld_o = busy;
  assign beat_bit_o = busy & pat_q[idx_q];

  // R5: a burst never holds more than eight beats
  a_r5_burst_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    left_q <= 4'(BEATS_FULL));

  // R6: a chopped burst that starts in the upper half stays there
  a_r6_upper_half: assert property (@(posedge clk) disable iff (!rst_ni)
    (tail_vld && tail_desc.upper) |=> (idx_q == 3'd4 && left_q == 4'(BEATS_CHOP)));

endmodule

// File: rtl/mpreg_readout.sv
module mpreg_readout
  import mpreg_pkg::*;
#(
  parameter int unsigned DQ_BYTES = 1,
  parameter int unsigned RD_LAT   = 5,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BANK_W   = 3,
  parameter logic [7:0]  PATTERN  = 8'b0101_0101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mrs_valid,
  input  logic [2:0]            mrs_addr,
  input  logic                  rd_valid,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [BANK_W-1:0]     rd_bank,
  input  logic                  wr_valid,
  input  logic [1:0]            burst_mode,
  input  logic                  lane_copy,
  output logic                  reg_mode,
  output logic [8*DQ_BYTES-1:0] dq,
  output logic                  dq_valid,
  output logic                  rd_addr_err,
  output logic                  array_rd,
  output logic                  array_wr,
  output logic                  wr_drop
);

  localparam int unsigned DQ_W = 8 * DQ_BYTES;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic        en;
  logic [1:0]  loc;
  logic        start;
  burst_desc_t desc;
  logic        beat_vld, beat_bit;

  mpreg_mode_reg i_mode (
    .clk         (clk),
    .rst_ni      (rst_sync_q),
    .mrs_valid_i (mrs_valid),
    .mrs_addr_i  (mrs_addr),
    .en_o        (en),
    .loc_o       (loc)
  );

  mpreg_cmd_decode #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .PATTERN (PATTERN)
  ) i_dec (
    .clk          (clk),
    .rst_ni       (rst_sync_q),
    .rd_valid_i   (rd_valid),
    .rd_addr_i    (rd_addr),
    .rd_bank_i    (rd_bank),
    .wr_valid_i   (wr_valid),
    .burst_mode_i (burst_mode),
    .en_i         (en),
    .loc_i        (loc),
    .start_o      (start),
    .desc_o       (desc),
    .addr_err_o   (rd_addr_err),
    .array_rd_o   (array_rd),
    .array_wr_o   (array_wr),
    .wr_drop_o    (wr_drop)
  );

  mpreg_beat_gen #(
    .RD_LAT (RD_LAT)
  ) i_beat (
    .clk        (clk),
    .rst_ni     (rst_sync_q),
    .start_i    (start),
    .desc_i     (desc),
    .beat_vld_o (beat_vld),
    .beat_bit_o (beat_bit)
  );

  genvar b;
  generate
    for (b = 0; b < int'(DQ_BYTES); b++) begin : g_lane
      always_comb begin
        dq[8*b]         = beat_bit;
        dq[8*b+1 +: 7]  = lane_copy ? {7{beat_bit}} : 7'b0;
      end
    end
  endgenerate

  assign dq_valid = beat_vld;
  assign reg_mode = en;

  // R10: every lane carries the same byte
  a_r10_lanes_match: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dq == {DQ_BYTES{dq[7:0]}});

  // R10: without copy only bit 0 of a lane may be set
  a_r10_zero_fill: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !lane_copy |-> ($countones(dq) <= int'(DQ_BYTES)));

  // R5: no data outside a burst
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !dq_valid |-> (dq == '0));

  // R11: a command edge produces at most one command flag
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({array_wr, wr_drop}));

  initial begin
    a_r5_lat_min: assert (RD_LAT >= 1);
    a_r10_bytes: assert (DQ_W >= 8);
  end

endmodule

// File: tb/test_mpreg_readout.sv
module test_mpreg_readout;

  localparam int         BYTES = 2;
  localparam int         RL    = 3;
  localparam logic [7:0] PAT   = 8'b0011_1010;

  logic        clk;
  logic        rst_n;
  logic        mrs_valid;
  logic [2:0]  mrs_addr;
  logic        rd_valid;
  logic [15:0] rd_addr;
  logic [2:0]  rd_bank;
  logic        wr_valid;
  logic [1:0]  burst_mode;
  logic        lane_copy;
  logic        reg_mode;
  logic [8*BYTES-1:0] dq;
  logic        dq_valid, rd_addr_err, array_rd, array_wr, wr_drop;

  mpreg_readout #(
    .DQ_BYTES (BYTES),
    .RD_LAT   (RL),
    .PATTERN  (PAT)
  ) i_mpreg_readout (
    .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_addr(mrs_addr),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_bank(rd_bank),
    .wr_valid(wr_valid), .burst_mode(burst_mode), .lane_copy(lane_copy),
    .reg_mode(reg_mode), .dq(dq), .dq_valid(dq_valid),
    .rd_addr_err(rd_addr_err), .array_rd(array_rd), .array_wr(array_wr),
    .wr_drop(wr_drop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  string cur_req = "R1";
  bit done = 0;

  // Reference model state
  bit       m_en;
  bit [1:0] m_loc;
  bit e_v   [int];
  bit e_b   [int];
  bit e_err [int];
  bit e_ard [int];
  bit e_awr [int];
  bit e_drp [int];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_en  = 0;
      m_loc = 0;
    end else begin
      if (rd_valid) begin
        if (!m_en) e_ard[cyc] = 1;
        else begin
          bit chop, up, err;
          bit [7:0] p;
          case (burst_mode)
            2'b10:   chop = 1;
            2'b01:   chop = !rd_addr[12];
            default: chop = 0;
          endcase
          err = (rd_addr[1:0] != 0) || (!chop && rd_addr[2]);
          up  = chop && rd_addr[2];
          p   = (m_loc == 0) ? PAT : 8'h00;
          if (err) e_err[cyc] = 1;
          for (int k = 0; k < (chop ? 4 : 8); k++) begin
            e_v[cyc+RL+k] = 1;
            e_b[cyc+RL+k] = p[(up ? 4 : 0) + k];
          end
        end
      end
      if (wr_valid) begin
        if (m_en) e_drp[cyc] = 1;
        else      e_awr[cyc] = 1;
      end
      if (mrs_valid) begin
        m_en  = mrs_addr[2];
        m_loc = mrs_addr[1:0];
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit v, bt;
      logic [8*BYTES-1:0] edq;
      v  = e_v.exists(cyc);
      bt = v ? e_b[cyc] : 1'b0;
      for (int b = 0; b < BYTES; b++)
        edq[8*b +: 8] = lane_copy ? {8{bt}} : {7'b0, bt};
      chk("dq_valid", 32'(dq_valid), 32'(v));
      chk("dq", 32'(dq), 32'(edq));
      chk("rd_addr_err", 32'(rd_addr_err), 32'(e_err.exists(cyc)));
      chk("array_rd", 32'(array_rd), 32'(e_ard.exists(cyc)));
      chk("array_wr", 32'(array_wr), 32'(e_awr.exists(cyc)));
      chk("wr_drop", 32'(wr_drop), 32'(e_drp.exists(cyc)));
      chk("reg_mode", 32'(reg_mode), 32'(m_en));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_mrs(input logic [2:0] a);
    mrs_valid = 1; mrs_addr = a; tick(1);
    mrs_valid = 0; mrs_addr = 3'b000; tick(3);
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [2:0] bk);
    rd_valid = 1; rd_addr = a; rd_bank = bk; tick(1);
    rd_valid = 0; rd_addr = 16'h0; rd_bank = 3'b0; tick(RL + 10);
  endtask

  task automatic do_wr();
    wr_valid = 1; tick(1);
    wr_valid = 0; tick(3);
  endtask

  initial begin
    rst_n = 0; mrs_valid = 0; mrs_addr = 0; rd_valid = 0; rd_addr = 0;
    rd_bank = 0; wr_valid = 0; burst_mode = 2'b00; lane_copy = 1;
    tick(4);
    cur_req = "R1"; rst_n = 1; tick(4);

    cur_req = "R3";  do_rd(16'h0004, 3'd5);          // normal read -> array
    cur_req = "R11"; do_wr();                        // normal write -> array
    cur_req = "R2";  do_mrs(3'b100);                 // enable, location 0
    cur_req = "R6";  do_rd(16'h0000, 3'd0);          // BL8 order 0..7
    cur_req = "R10"; lane_copy = 0; do_rd(16'h0000, 3'd0); lane_copy = 1;
    cur_req = "R7";  burst_mode = 2'b10; do_rd(16'h0000, 3'd0); // chop low half
    cur_req = "R6";  do_rd(16'h0004, 3'd0);          // chop upper half
    cur_req = "R7";  burst_mode = 2'b01; do_rd(16'h1000, 3'd0); // otf BL8
    cur_req = "R7";  do_rd(16'h0004, 3'd0);          // otf chop upper
    cur_req = "R7";  burst_mode = 2'b11; do_rd(16'h0000, 3'd0); // reserved -> BL8
    cur_req = "R8";  burst_mode = 2'b00; do_rd(16'hEFF8, 3'd7); // ignored bits
    cur_req = "R8";  burst_mode = 2'b10; do_rd(16'hFFFC, 3'd3); // A12 ignored, chop
    cur_req = "R9";  burst_mode = 2'b00; do_rd(16'h0003, 3'd0); // A[1:0] illegal
    cur_req = "R9";  do_rd(16'h0004, 3'd0);          // BL8 with A2 set
    cur_req = "R5";  do_rd(16'h0000, 3'd1);
    cur_req = "R11"; do_wr();                        // dropped
    cur_req = "R4";  do_mrs(3'b110); do_rd(16'h0000, 3'd0); // location 2 -> zeros
    cur_req = "R4";  do_mrs(3'b101); do_rd(16'h0000, 3'd0); // location 1 -> zeros
    cur_req = "R2";  do_mrs(3'b011); do_rd(16'h0000, 3'd0); // back to normal
    cur_req = "R11"; do_wr();
    tick(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule